// File: doc/BRIEF.md
# Diagnostic Progress Code Display

This block watches a simple legacy I/O write bus and captures the progress codes that boot firmware writes to a fixed diagnostic port. The captured value drives a row of seven-segment hex digits and stays there until another qualifying write arrives. If the machine hangs, the last test point reached is still on the display.

A mode input picks which of two port addresses is snooped. A byte write updates only the low byte. A 16-bit word write updates both bytes. In a word write, the high byte names the bus routine that is executing: its upper nibble is a function number and its lower nibble is a bus number. The block splits that byte into the two nibbles and raises a flag when either nibble is outside its legal range.

Top module: `post_code_display`

## Requirements
- R1: With `alt_port_sel` = 0, a write to I/O address 0x0080 is captured. A write to 0x0300 leaves every output unchanged.
- R2: With `alt_port_sel` = 1, a write to I/O address 0x0300 is captured. A write to 0x0080 leaves every output unchanged.
- R3: The captured value is held for any number of cycles until the next qualifying write. A cycle with `io_wr` = 0 captures nothing, even when the address and data match.
- R4: A word write (`io_be` = 2'b11) loads all 16 bits of `io_data` into `code_out` and sets `word_valid`. Both changes are visible after the clock edge that samples the write.
- R5: `func_idx` equals `code_out[15:12]` and `bus_idx` equals `code_out[11:8]`.
- R6: `route_invalid` is 1 exactly when `word_valid` is 1 and either the function nibble is greater than 7 or the bus nibble is greater than 5. The values 7 and 5 are legal.
- R7: A byte write (`io_be` = 2'b01) loads `io_data[7:0]` into `code_out[7:0]`, keeps `code_out[15:8]` unchanged, and clears `word_valid`. As a result, `route_invalid` is 0.
- R8: A write to the selected port with `io_be` = 2'b10 or 2'b00 has no effect on any output.
- R9: Digit i is output on `seg_n[7*i+6 : 7*i]` and shows nibble i of `code_out`. Bit 0 of each digit is segment a and bit 6 is segment g. Segments are active low. The glyphs are the usual hex patterns; for example, 0 is 7'h40, 7 is 7'h78 and F is 7'h0E.
- R10: A synchronous active-high `rst` clears `code_out` to 0x0000 and clears `word_valid`. After reset, every digit shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O write address |
| io_data | input | 16 | I/O write data |
| io_be | input | 2 | Byte enables; bit 0 is the low byte |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| alt_port_sel | input | 1 | 0 selects port 0x0080, 1 selects port 0x0300 |
| code_out | output | 16 | Captured progress code |
| word_valid | output | 1 | Last capture was a word write |
| func_idx | output | 4 | Function nibble of the high byte |
| bus_idx | output | 4 | Bus nibble of the high byte |
| route_invalid | output | 1 | Function or bus nibble out of range in a word capture |
| seg_n | output | 28 | Active-low segments, 7 per digit, digit 0 lowest |

## Verification
The assertions check four things on every clock edge:
- the latch holds its value on cycles without a hit;
- a word hit loads the full data and sets the word flag;
- a byte hit keeps the high byte and clears the word flag;
- reset clears the state, and the range flag is never raised without a word capture.

Only the bench scenarios can show the rest. That covers the address selection between the two ports, the rejection of partial byte-enable patterns, and the exact glyph on each digit for all sixteen nibble values. It also covers the 7 and 5 range boundaries against 8 and 6.

// File: rtl/post_disp_pkg.sv
package post_disp_pkg;

  localparam int NIBBLE_W = 4;
  localparam int SEG_W    = 7;

  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_BYTE = 2'd1,
    XFER_WORD = 2'd2
  } xfer_e;

  // Byte-enable pattern to transfer kind; an upper-only lane is not a checkpoint.
  function automatic xfer_e classify_be(input logic [1:0] be);
    case (be)
      2'b11:   return XFER_WORD;
      2'b01:   return XFER_BYTE;
      default: return XFER_NONE;
    endcase
  endfunction

  // Active-low segments, bit0 = a ... bit6 = g.
  function automatic logic [SEG_W-1:0] hex_to_seg_n(input logic [NIBBLE_W-1:0] n);
    logic [SEG_W-1:0] lit;
    case (n)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

  function automatic logic nibble_over(input logic [NIBBLE_W-1:0] v,
                                       input logic [NIBBLE_W-1:0] limit);
    return v > limit;
  endfunction

endpackage

// File: rtl/post_port_match.sv
module post_port_match
  import post_disp_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PRI_PORT = 16'h0080,
  parameter logic [ADDR_W-1:0] ALT_PORT = 16'h0300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_be,
  input  logic              io_wr,
  input  logic              alt_port_sel,
  output logic              hit_byte,
  output logic              hit_word
);

  logic [ADDR_W-1:0] target_port;
  logic              addr_hit;
  xfer_e             kind;

  assign target_port = alt_port_sel ? ALT_PORT : PRI_PORT;
  assign addr_hit    = io_wr && (io_addr == target_port);
  assign kind        = classify_be(io_be);
  assign hit_byte    = addr_hit && (kind == XFER_BYTE);
  assign hit_word    = addr_hit && (kind == XFER_WORD);

  // R8
  hit_kind_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_byte, hit_word}));

  // R3
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_byte || hit_word) |-> io_wr);

endmodule

// File: rtl/post_code_latch.sv
module post_code_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_byte,
  input  logic              hit_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] code,
  output logic              word_valid
);

  localparam int LO_W = DATA_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      code       <= '0;
      word_valid <= 1'b0;
    end else if (hit_word) begin
      code       <= wdata;
      word_valid <= 1'b1;
    end else if (hit_byte) begin
      code[LO_W-1:0] <= wdata[LO_W-1:0];
      word_valid     <= 1'b0;
    end
  end

  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_byte && !hit_word) |=> ($stable(code) && $stable(word_valid)));

  // R4
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit_word |=> (word_valid && code == $past(wdata)));

  // R7
  byte_keep_hi_chk: assert property (@(posedge clk) disable iff (rst)
    hit_byte |=> (!word_valid
                  && code[DATA_W-1:LO_W] == $past(code[DATA_W-1:LO_W])
                  && code[LO_W-1:0] == $past(wdata[LO_W-1:0])));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (code == '0 && !word_valid));

endmodule

// File: rtl/post_route_decode.sv
module post_route_decode
  import post_disp_pkg::*;
#(
  parameter logic [NIBBLE_W-1:0] FUNC_MAX = 4'd7,
  parameter logic [NIBBLE_W-1:0] BUS_MAX  = 4'd5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          hi_byte,
  input  logic                word_valid,
  output logic [NIBBLE_W-1:0] func_idx,
  output logic [NIBBLE_W-1:0] bus_idx,
  output logic                route_invalid
);

  logic func_bad;
  logic bus_bad;

  assign func_idx      = hi_byte[7:4];
  assign bus_idx       = hi_byte[3:0];
  assign func_bad      = nibble_over(func_idx, FUNC_MAX);
  assign bus_bad       = nibble_over(bus_idx, BUS_MAX);
  assign route_invalid = word_valid && (func_bad || bus_bad);

  // R6
  legal_route_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (func_idx <= FUNC_MAX && bus_idx <= BUS_MAX) |-> !route_invalid);

endmodule

// File: rtl/post_seg_bank.sv
module post_seg_bank
  import post_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS*NIBBLE_W-1:0] value,
  output logic [NUM_DIGITS*SEG_W-1:0]    seg_n
);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign seg_n[g*SEG_W +: SEG_W] = hex_to_seg_n(value[g*NIBBLE_W +: NIBBLE_W]);
  end

endmodule

// File: rtl/post_code_display.sv
module post_code_display
  import post_disp_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PRI_PORT   = 16'h0080,
  parameter logic [ADDR_W-1:0] ALT_PORT   = 16'h0300,
  parameter int                NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic [15:0]                 io_data,
  input  logic [1:0]                  io_be,
  input  logic                        io_wr,
  input  logic                        alt_port_sel,
  output logic [15:0]                 code_out,
  output logic                        word_valid,
  output logic [3:0]                  func_idx,
  output logic [3:0]                  bus_idx,
  output logic                        route_invalid,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_n
);

  localparam int DATA_W  = 16;
  localparam int SHOWN_W = NUM_DIGITS * NIBBLE_W;

  logic hit_byte;
  logic hit_word;

  post_port_match #(
    .ADDR_W  (ADDR_W),
    .PRI_PORT(PRI_PORT),
    .ALT_PORT(ALT_PORT)
  ) u_match (
    .clk         (clk),
    .rst         (rst),
    .io_addr     (io_addr),
    .io_be       (io_be),
    .io_wr       (io_wr),
    .alt_port_sel(alt_port_sel),
    .hit_byte    (hit_byte),
    .hit_word    (hit_word)
  );

  post_code_latch #(.DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .hit_byte  (hit_byte),
    .hit_word  (hit_word),
    .wdata     (io_data),
    .code      (code_out),
    .word_valid(word_valid)
  );

  post_route_decode u_route (
    .clk          (clk),
    .rst          (rst),
    .hi_byte      (code_out[15:8]),
    .word_valid   (word_valid),
    .func_idx     (func_idx),
    .bus_idx      (bus_idx),
    .route_invalid(route_invalid)
  );

  post_seg_bank #(.NUM_DIGITS(NUM_DIGITS)) u_segs (
    .value(code_out[SHOWN_W-1:0]),
    .seg_n(seg_n)
  );

  // R6
  invalid_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    route_invalid |-> word_valid);

endmodule

// File: tb/post_code_display_tb.sv
module post_code_display_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr;
  logic [15:0] io_data;
  logic [1:0]  io_be;
  logic        io_wr;
  logic        alt_port_sel;
  logic [15:0] code_out;
  logic        word_valid;
  logic [3:0]  func_idx;
  logic [3:0]  bus_idx;
  logic        route_invalid;
  logic [27:0] seg_n;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] m_code;
  logic        m_wv;

  always #4 clk = ~clk;

  post_code_display u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_data(io_data), .io_be(io_be),
    .io_wr(io_wr), .alt_port_sel(alt_port_sel), .code_out(code_out),
    .word_valid(word_valid), .func_idx(func_idx), .bus_idx(bus_idx),
    .route_invalid(route_invalid), .seg_n(seg_n)
  );

  // Lit segments gfedcba per hex glyph, inverted for active-low drive.
  function automatic logic [6:0] glyph_n(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      0: on = 7'b0111111;  1: on = 7'b0000110;  2: on = 7'b1011011;  3: on = 7'b1001111;
      4: on = 7'b1100110;  5: on = 7'b1101101;  6: on = 7'b1111101;  7: on = 7'b0000111;
      8: on = 7'b1111111;  9: on = 7'b1101111; 10: on = 7'b1110111; 11: on = 7'b1111100;
      12: on = 7'b0111001; 13: on = 7'b1011110; 14: on = 7'b1111001; default: on = 7'b1110001;
    endcase
    return ~on;
  endfunction

  task automatic expect32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic exp_bad;
    exp_bad = m_wv && ((m_code[15:12] >= 4'd8) || (m_code[11:8] >= 4'd6));
    expect32(req, "code_out", 32'(code_out), 32'(m_code));
    expect32(req, "word_valid", 32'(word_valid), 32'(m_wv));
    expect32(req, "func_idx", 32'(func_idx), 32'(m_code[15:12]));
    expect32(req, "bus_idx", 32'(bus_idx), 32'(m_code[11:8]));
    expect32(req, "route_invalid", 32'(route_invalid), 32'(exp_bad));
    for (int i = 0; i < 4; i++)
      expect32(req, "seg_n digit", 32'(seg_n[i*7 +: 7]), 32'(glyph_n(m_code[i*4 +: 4])));
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d,
                           input logic [1:0] be, input logic wr);
    logic [15:0] port;
    @(negedge clk);
    io_addr = a; io_data = d; io_be = be; io_wr = wr;
    @(negedge clk);
    io_wr = 1'b0; io_be = 2'b00; io_data = 16'hDEAD; io_addr = 16'h0000;
    port = alt_port_sel ? 16'h0300 : 16'h0080;
    if (wr && a == port) begin
      if (be == 2'b11) begin m_code = d; m_wv = 1'b1; end
      else if (be == 2'b01) begin m_code[7:0] = d[7:0]; m_wv = 1'b0; end
    end
  endtask

  task automatic t_reset();
    bus_write(16'h0080, 16'h3456, 2'b11, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_code = 16'h0000; m_wv = 1'b0;
    check_all("R10");
    expect32("R10", "digit0 zero glyph", 32'(seg_n[6:0]), 32'h40);
  endtask

  task automatic t_primary();
    alt_port_sel = 1'b0;
    bus_write(16'h0080, 16'h00A5, 2'b01, 1'b1);
    check_all("R1");
    expect32("R1", "low byte", 32'(code_out[7:0]), 32'hA5);
    bus_write(16'h0300, 16'h1177, 2'b11, 1'b1);
    check_all("R1");
    expect32("R1", "alt port ignored", 32'(code_out), 32'h00A5);
  endtask

  task automatic t_alt();
    alt_port_sel = 1'b1;
    bus_write(16'h0300, 16'h2431, 2'b11, 1'b1);
    check_all("R2");
    expect32("R2", "alt captured", 32'(code_out), 32'h2431);
    bus_write(16'h0080, 16'h0099, 2'b01, 1'b1);
    check_all("R2");
    expect32("R2", "primary ignored", 32'(code_out), 32'h2431);
    alt_port_sel = 1'b0;
  endtask

  task automatic t_hold();
    bus_write(16'h0080, 16'h5217, 2'b11, 1'b1);
    bus_write(16'h0080, 16'hFFFF, 2'b11, 1'b0);
    repeat (20) @(negedge clk);
    check_all("R3");
    expect32("R3", "held code", 32'(code_out), 32'h5217);
  endtask

  task automatic t_word_decode();
    bus_write(16'h0080, 16'h352A, 2'b11, 1'b1);
    check_all("R4");
    expect32("R5", "func", 32'(func_idx), 32'h3);
    expect32("R5", "bus", 32'(bus_idx), 32'h5);
    expect32("R6", "legal", 32'(route_invalid), 32'h0);
  endtask

  task automatic t_range();
    bus_write(16'h0080, 16'h7500, 2'b11, 1'b1);
    expect32("R6", "7/5 legal", 32'(route_invalid), 32'h0);
    check_all("R6");
    bus_write(16'h0080, 16'h8000, 2'b11, 1'b1);
    expect32("R6", "func 8", 32'(route_invalid), 32'h1);
    bus_write(16'h0080, 16'h0600, 2'b11, 1'b1);
    expect32("R6", "bus 6", 32'(route_invalid), 32'h1);
    bus_write(16'h0080, 16'hFF00, 2'b11, 1'b1);
    check_all("R6");
  endtask

  task automatic t_byte();
    bus_write(16'h0080, 16'h9C11, 2'b11, 1'b1);
    expect32("R7", "pre invalid", 32'(route_invalid), 32'h1);
    bus_write(16'h0080, 16'h4442, 2'b01, 1'b1);
    check_all("R7");
    expect32("R7", "hi kept lo new", 32'(code_out), 32'h9C42);
    expect32("R7", "word flag clear", 32'(word_valid), 32'h0);
    expect32("R7", "invalid cleared", 32'(route_invalid), 32'h0);
  endtask

  task automatic t_partial_be();
    bus_write(16'h0080, 16'h1234, 2'b11, 1'b1);
    bus_write(16'h0080, 16'hABCD, 2'b10, 1'b1);
    check_all("R8");
    bus_write(16'h0080, 16'hABCD, 2'b00, 1'b1);
    check_all("R8");
    expect32("R8", "unchanged", 32'(code_out), 32'h1234);
  endtask

  task automatic t_glyphs();
    bus_write(16'h0080, 16'h3210, 2'b11, 1'b1); check_all("R9");
    bus_write(16'h0080, 16'h7654, 2'b11, 1'b1); check_all("R9");
    expect32("R9", "digit3 is 7", 32'(seg_n[27:21]), 32'h78);
    bus_write(16'h0080, 16'hBA98, 2'b11, 1'b1); check_all("R9");
    bus_write(16'h0080, 16'hFEDC, 2'b11, 1'b1); check_all("R9");
    expect32("R9", "digit3 is F", 32'(seg_n[27:21]), 32'h0E);
  endtask

  initial begin
    rst = 1'b1; io_addr = '0; io_data = '0; io_be = '0; io_wr = 1'b0;
    alt_port_sel = 1'b0; m_code = '0; m_wv = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R10");
    t_reset();
    t_primary();
    t_alt();
    t_hold();
    t_word_decode();
    t_range();
    t_byte();
    t_partial_be();
    t_glyphs();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule